// File: doc/BRIEF.md
# Compact fetch-stage branch predictor

This unit sits beside the fetch stage of a shallow in-order pipeline, one instruction per cycle. Each cycle the fetch address arrives with a pre-decoded branch flag, a branch kind and the encoded offset. In the same cycle, through combinational logic, the unit returns a next fetch address and a taken decision. For a taken direct branch or call whose address it has seen before, it also supplies the instruction word found at the target, so the pipeline loses no bubble on the redirect.

Four structures are involved. Direct targets are always computed as fetch address plus offset and are never stored. A small fully associative target buffer holds targets for indirect branches only. A table of 2-bit counters, indexed purely by an 8-bit global history, predicts direct-branch direction. A circular return stack predicts return targets. Execute feeds resolved outcomes back through an update port that also carries the history checkpoint taken at prediction time, and a mispredict restores the history from it.

Top module: `bpu_top`

## Requirements
- R1: For a fetch that is not a branch, the predictor drives next address = fetch address + 4 and taken = 0.
- R2: Direct-branch direction comes from 256 two-bit counters indexed by the current 8-bit history. Each counter resets to 1, predicts taken when its value is 2 or more, and saturates at 0 and 3. A direct update (kind code 0) trains the counter at the checkpoint index it carries.
- R3: Kind codes are 0 direct, 1 indirect, 2 call, 3 return. A call always predicts taken. A direct branch or call predicted taken goes to fetch address + offset.
- R4: A direct-branch fetch shifts its predicted direction into the history LSB. The history value before the shift is output as the checkpoint. A mispredict update reloads the history from its checkpoint. For a direct kind the actual outcome is then shifted in; for other kinds the checkpoint is loaded unshifted. A mispredict takes precedence over a fetch shift in the same cycle.
- R5: A call fetch pushes fetch address + 4 onto an 8-entry stack. A return fetch predicts taken to the top entry and pops it, in last-in first-out order.
- R6: A push onto a full stack overwrites the oldest entry. A pop on an empty stack returns the most recently written entry and leaves the stack unchanged.
- R7: An indirect fetch that hits the target buffer predicts taken to the stored target. On a miss it predicts not taken to fetch address + 4. Only taken indirect updates write the buffer; direct updates never do.
- R8: The indirect buffer has 8 fully associative entries with round-robin allocation. An update to a present tag whose target changed is written in place. An update with a matching tag and target writes nothing and does not advance the allocation pointer.
- R9: A 4-entry fully associative target-instruction cache, written by taken direct or call updates with round-robin allocation, flags a hit and supplies the stored instruction word on a predicted-taken direct or call fetch. It never flags a hit for a non-branch fetch.
- R10: A flush clears every valid bit in both target structures, so later lookups miss until new updates are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate both target structures |
| f_valid_i | input | 1 | Fetch slot valid |
| f_pc_i | input | 32 | Fetch address |
| f_is_br_i | input | 1 | Pre-decode: instruction is a branch |
| f_kind_i | input | 2 | Branch kind: 0 direct, 1 indirect, 2 call, 3 return |
| f_off_i | input | 32 | Decoded branch offset |
| p_taken_o | output | 1 | Predicted taken |
| p_npc_o | output | 32 | Predicted next fetch address |
| p_tic_hit_o | output | 1 | Target instruction supplied |
| p_tic_instr_o | output | 32 | Instruction word at the target |
| p_hist_o | output | 8 | History checkpoint for this fetch |
| u_valid_i | input | 1 | Resolved branch update valid |
| u_pc_i | input | 32 | Resolved branch address |
| u_kind_i | input | 2 | Resolved branch kind |
| u_taken_i | input | 1 | Actual outcome |
| u_target_i | input | 32 | Actual target |
| u_tgt_instr_i | input | 32 | Instruction word at the actual target |
| u_hist_i | input | 8 | Checkpoint carried from prediction |
| u_mispred_i | input | 1 | Prediction was wrong |

## Verification
The direction table is driven by a sequence of training updates at one history index. The sequence separates true saturating counting from wrapping arithmetic and checks the taken threshold at 2. History checks set a shift, a direct restore and a non-direct restore against each other, each producing a distinct history value. Return-stack tests use a single call, nested calls and a nine-deep overflow followed by an extra pop, which tells wrapping apart from clamping and shows the empty-pop rule. Indirect-buffer tests fill past capacity and then send a same-target update and a changed-target update; only allocation that is round-robin, write-on-change and in place leaves every expected tag resident.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    BK_DIR  = 2'd0,
    BK_IND  = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bpu_cam.sv
// Fully associative tag/data store, round-robin allocation, in-place rewrite.
module bpu_cam #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned DAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [DAT_W-1:0] lk_dat_o,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             wr_hit_o,
  output logic [DAT_W-1:0] wr_cur_o,
  input  logic             wr_en_i,
  input  logic [DAT_W-1:0] wr_dat_i
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [DAT_W-1:0] dat_q [N];
  logic [IW-1:0]    rr_q;
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    slot;

  always_comb begin
    lk_hit_o = 1'b0;
    lk_dat_o = '0;
    wr_hit_o = 1'b0;
    wr_cur_o = '0;
    wr_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && tag_q[i] == lk_tag_i) begin
        lk_hit_o = 1'b1;
        lk_dat_o = dat_q[i];
      end
      if (vld_q[i] && tag_q[i] == wr_tag_i) begin
        wr_hit_o = 1'b1;
        wr_cur_o = dat_q[i];
        wr_idx   = IW'(i);
      end
    end
    slot = wr_hit_o ? wr_idx : rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[slot] <= 1'b1;
      tag_q[slot] <= wr_tag_i;
      dat_q[slot] <= wr_dat_i;
      if (!wr_hit_o) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpu_dir.sv
// Global-history indexed 2-bit counter table with checkpoint restore.
module bpu_dir #(
  parameter int unsigned HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  output logic          taken_o,
  output logic [HW-1:0] hist_o,
  input  logic          train_i,
  input  logic [HW-1:0] train_idx_i,
  input  logic          train_taken_i,
  input  logic          restore_i,
  input  logic          restore_push_i,
  input  logic          restore_bit_i
);
  localparam int unsigned ENT = 1 << HW;

  logic [1:0]    ctr_q [ENT];
  logic [HW-1:0] hist_q;
  logic [1:0]    cur;

  assign taken_o = ctr_q[hist_q][1];
  assign hist_o  = hist_q;
  assign cur     = ctr_q[train_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENT; i++) ctr_q[i] <= 2'd1;
    end else if (train_i) begin
      if (train_taken_i && cur != 2'd3)       ctr_q[train_idx_i] <= cur + 2'd1;
      else if (!train_taken_i && cur != 2'd0) ctr_q[train_idx_i] <= cur - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (restore_i) begin
      hist_q <= restore_push_i ? {train_idx_i[HW-2:0], restore_bit_i} : train_idx_i;
    end else if (shift_i) begin
      hist_q <= {hist_q[HW-2:0], taken_o};
    end
  end
endmodule

// File: rtl/bpu_ras.sv
// Circular return stack; empty pop returns the last written slot.
module bpu_ras #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_dat_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned CW = $clog2(N + 1);

  logic [AW-1:0] mem_q [N];
  logic [IW-1:0] tos_q, lw_q, tos_inc, tos_dec;
  logic [CW-1:0] cnt_q;

  assign tos_inc = (tos_q == IW'(N - 1)) ? '0 : tos_q + 1'b1;
  assign tos_dec = (tos_q == '0) ? IW'(N - 1) : tos_q - 1'b1;
  assign top_o   = (cnt_q != '0) ? mem_q[tos_q] : mem_q[lw_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= IW'(N - 1);
      lw_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[tos_inc] <= push_dat_i;
      tos_q          <= tos_inc;
      lw_q           <= tos_inc;
      if (cnt_q != CW'(N)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      tos_q <= tos_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bpu_top.sv
module bpu_top
  import bpu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned HIST_W  = 8,
  parameter int unsigned TIC_N   = 4,
  parameter int unsigned IBUF_N  = 8,
  parameter int unsigned RAS_N   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               f_valid_i,
  input  logic [XLEN-1:0]    f_pc_i,
  input  logic               f_is_br_i,
  input  logic [1:0]         f_kind_i,
  input  logic [XLEN-1:0]    f_off_i,
  output logic               p_taken_o,
  output logic [XLEN-1:0]    p_npc_o,
  output logic               p_tic_hit_o,
  output logic [INSTR_W-1:0] p_tic_instr_o,
  output logic [HIST_W-1:0]  p_hist_o,
  input  logic               u_valid_i,
  input  logic [XLEN-1:0]    u_pc_i,
  input  logic [1:0]         u_kind_i,
  input  logic               u_taken_i,
  input  logic [XLEN-1:0]    u_target_i,
  input  logic [INSTR_W-1:0] u_tgt_instr_i,
  input  logic [HIST_W-1:0]  u_hist_i,
  input  logic               u_mispred_i
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] seq_pc, dir_tgt, ras_top, ib_tgt, ib_cur;
  logic            f_br, f_dir, f_ind, f_call, f_ret;
  logic            u_dir, u_ind, u_call;
  logic            dir_taken, ib_hit, ib_wr_hit, ib_wr;
  logic            tic_hit, tic_wr_hit, tic_wr;
  logic [INSTR_W-1:0] tic_dat, tic_cur;

  assign f_br   = f_valid_i && f_is_br_i;
  assign f_dir  = f_br && br_kind_e'(f_kind_i) == BK_DIR;
  assign f_ind  = f_br && br_kind_e'(f_kind_i) == BK_IND;
  assign f_call = f_br && br_kind_e'(f_kind_i) == BK_CALL;
  assign f_ret  = f_br && br_kind_e'(f_kind_i) == BK_RET;
  assign u_dir  = u_valid_i && br_kind_e'(u_kind_i) == BK_DIR;
  assign u_ind  = u_valid_i && br_kind_e'(u_kind_i) == BK_IND;
  assign u_call = u_valid_i && br_kind_e'(u_kind_i) == BK_CALL;

  assign seq_pc  = f_pc_i + STEP;
  assign dir_tgt = f_pc_i + f_off_i;

  bpu_dir #(.HW(HIST_W)) u_dir_pred (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shift_i       (f_dir),
    .taken_o       (dir_taken),
    .hist_o        (p_hist_o),
    .train_i       (u_dir),
    .train_idx_i   (u_hist_i),
    .train_taken_i (u_taken_i),
    .restore_i     (u_valid_i && u_mispred_i),
    .restore_push_i(u_dir),
    .restore_bit_i (u_taken_i)
  );

  bpu_ras #(.N(RAS_N), .AW(XLEN)) u_ras (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (f_call),
    .push_dat_i(seq_pc),
    .pop_i     (f_ret),
    .top_o     (ras_top)
  );

  // Indirect targets only; rewrite only when missing or changed.
  assign ib_wr = u_ind && u_taken_i && (!ib_wr_hit || ib_cur != u_target_i);

  bpu_cam #(.N(IBUF_N), .TAG_W(XLEN), .DAT_W(XLEN)) u_ibuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .lk_tag_i(f_pc_i),
    .lk_hit_o(ib_hit),
    .lk_dat_o(ib_tgt),
    .wr_tag_i(u_pc_i),
    .wr_hit_o(ib_wr_hit),
    .wr_cur_o(ib_cur),
    .wr_en_i (ib_wr),
    .wr_dat_i(u_target_i)
  );

  assign tic_wr = (u_dir || u_call) && u_taken_i;

  bpu_cam #(.N(TIC_N), .TAG_W(XLEN), .DAT_W(INSTR_W)) u_tic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .lk_tag_i(f_pc_i),
    .lk_hit_o(tic_hit),
    .lk_dat_o(tic_dat),
    .wr_tag_i(u_pc_i),
    .wr_hit_o(tic_wr_hit),
    .wr_cur_o(tic_cur),
    .wr_en_i (tic_wr),
    .wr_dat_i(u_tgt_instr_i)
  );

  logic tic_unused;
  assign tic_unused = tic_wr_hit ^ (^tic_cur);

  always_comb begin
    p_taken_o = 1'b0;
    p_npc_o   = seq_pc;
    if (f_ret) begin
      p_taken_o = 1'b1;
      p_npc_o   = ras_top;
    end else if (f_ind) begin
      p_taken_o = ib_hit;
      p_npc_o   = ib_hit ? ib_tgt : seq_pc;
    end else if (f_call || (f_dir && dir_taken)) begin
      p_taken_o = 1'b1;
      p_npc_o   = dir_tgt;
    end
  end

  assign p_tic_hit_o   = tic_hit && (f_call || (f_dir && dir_taken));
  assign p_tic_instr_o = p_tic_hit_o ? tic_dat : '0;
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              f_valid_i,
  input logic [XLEN-1:0]   f_pc_i,
  input logic              f_is_br_i,
  input logic [1:0]        f_kind_i,
  input logic              p_taken_o,
  input logic [XLEN-1:0]   p_npc_o,
  input logic              p_tic_hit_o,
  input logic [HIST_W-1:0] p_hist_o,
  input logic              u_valid_i,
  input logic [1:0]        u_kind_i,
  input logic              u_taken_i,
  input logic [HIST_W-1:0] u_hist_i,
  input logic              u_mispred_i
);
  // R1
  seq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_valid_i && !f_is_br_i) |-> (!p_taken_o && p_npc_o == f_pc_i + XLEN'(4)));

  // R7
  not_taken_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_valid_i && !p_taken_o) |-> (p_npc_o == f_pc_i + XLEN'(4)));

  // R3
  call_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_valid_i && f_is_br_i && f_kind_i == 2'd2) |-> p_taken_o);

  // R9
  tic_needs_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_tic_hit_o |-> (p_taken_o && f_valid_i && f_is_br_i));

  // R4
  hist_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_valid_i && u_mispred_i && u_kind_i == 2'd0) |=>
      (p_hist_o == {$past(u_hist_i[HIST_W-2:0]), $past(u_taken_i)}));

  // R4
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(u_valid_i && u_mispred_i) && !(f_valid_i && f_is_br_i && f_kind_i == 2'd0))
      |=> $stable(p_hist_o));

  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !p_tic_hit_o);
endmodule

bind bpu_top bpu_chk #(.XLEN(XLEN), .HIST_W(HIST_W)) u_bpu_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .f_valid_i  (f_valid_i),
  .f_pc_i     (f_pc_i),
  .f_is_br_i  (f_is_br_i),
  .f_kind_i   (f_kind_i),
  .p_taken_o  (p_taken_o),
  .p_npc_o    (p_npc_o),
  .p_tic_hit_o(p_tic_hit_o),
  .p_hist_o   (p_hist_o),
  .u_valid_i  (u_valid_i),
  .u_kind_i   (u_kind_i),
  .u_taken_i  (u_taken_i),
  .u_hist_i   (u_hist_i),
  .u_mispred_i(u_mispred_i)
);

// File: tb/bpu_top_tb.sv
`timescale 1ns/1ps
module bpu_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        f_valid_i = 1'b0;
  logic [31:0] f_pc_i = '0;
  logic        f_is_br_i = 1'b0;
  logic [1:0]  f_kind_i = '0;
  logic [31:0] f_off_i = '0;
  logic        p_taken_o;
  logic [31:0] p_npc_o;
  logic        p_tic_hit_o;
  logic [31:0] p_tic_instr_o;
  logic [7:0]  p_hist_o;
  logic        u_valid_i = 1'b0;
  logic [31:0] u_pc_i = '0;
  logic [1:0]  u_kind_i = '0;
  logic        u_taken_i = 1'b0;
  logic [31:0] u_target_i = '0;
  logic [31:0] u_tgt_instr_i = '0;
  logic [7:0]  u_hist_i = '0;
  logic        u_mispred_i = 1'b0;

  localparam logic [1:0] K_DIR = 2'd0, K_IND = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bpu_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    f_valid_i = 1'b0; f_is_br_i = 1'b0; u_valid_i = 1'b0;
    u_mispred_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic br, input logic [1:0] kind,
                       input logic [31:0] off);
    @(negedge clk_i);
    idle_inputs();
    f_valid_i = 1'b1; f_pc_i = pc; f_is_br_i = br; f_kind_i = kind; f_off_i = off;
    #1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic [1:0] kind, input logic tk,
                     input logic [31:0] tgt, input logic [31:0] ins,
                     input logic [7:0] h, input logic mp);
    @(negedge clk_i);
    idle_inputs();
    u_valid_i = 1'b1; u_pc_i = pc; u_kind_i = kind; u_taken_i = tk;
    u_target_i = tgt; u_tgt_instr_i = ins; u_hist_i = h; u_mispred_i = mp;
  endtask

  task automatic t_reset();
    fetch(32'h100, 1'b0, K_DIR, 32'h0);
    chk("R1 npc", p_npc_o, 32'h104);
    chk("R1 taken", {31'b0, p_taken_o}, 32'h0);
    chk("R4 hist reset", {24'b0, p_hist_o}, 32'h0);
    fetch(32'h100, 1'b1, K_DIR, 32'h20);
    chk("R2 reset weak-nt", {31'b0, p_taken_o}, 32'h0);
    chk("R2 reset npc", p_npc_o, 32'h104);
  endtask

  task automatic t_dir();
    upd(32'h100, K_DIR, 1'b1, 32'h120, 32'h0, 8'h00, 1'b0);
    fetch(32'h100, 1'b1, K_DIR, 32'h20);
    chk("R2 threshold", {31'b0, p_taken_o}, 32'h1);
    chk("R3 direct target", p_npc_o, 32'h120);
    fetch(32'h108, 1'b0, K_DIR, 32'h0);
    chk("R4 shift", {24'b0, p_hist_o}, 32'h1);
    upd(32'h100, K_DIR, 1'b0, 32'h104, 32'h0, 8'h00, 1'b1);
    fetch(32'h108, 1'b0, K_DIR, 32'h0);
    chk("R4 restore nt", {24'b0, p_hist_o}, 32'h0);
    fetch(32'h100, 1'b1, K_DIR, 32'h20);
    chk("R2 decrement", {31'b0, p_taken_o}, 32'h0);
    for (int i = 0; i < 5; i++) upd(32'h100, K_DIR, 1'b1, 32'h120, 32'h0, 8'h00, 1'b0);
    upd(32'h100, K_DIR, 1'b0, 32'h104, 32'h0, 8'h00, 1'b0);
    fetch(32'h100, 1'b1, K_DIR, 32'h20);
    chk("R2 saturation", {31'b0, p_taken_o}, 32'h1);
    upd(32'h100, K_DIR, 1'b1, 32'h120, 32'h0, 8'h5A, 1'b1);
    fetch(32'h108, 1'b0, K_DIR, 32'h0);
    chk("R4 restore direct", {24'b0, p_hist_o}, 32'hB5);
    upd(32'hF00, K_IND, 1'b0, 32'h0, 32'h0, 8'h33, 1'b1);
    fetch(32'h108, 1'b0, K_DIR, 32'h0);
    chk("R4 restore nondirect", {24'b0, p_hist_o}, 32'h33);
  endtask

  task automatic t_ras();
    fetch(32'h200, 1'b1, K_CALL, 32'h100);
    chk("R3 call taken", {31'b0, p_taken_o}, 32'h1);
    chk("R3 call target", p_npc_o, 32'h300);
    fetch(32'h300, 1'b1, K_RET, 32'h0);
    chk("R5 return", p_npc_o, 32'h204);
    for (int i = 1; i <= 3; i++) fetch(32'h1000 * i, 1'b1, K_CALL, 32'h40);
    for (int i = 3; i >= 1; i--) begin
      fetch(32'h50, 1'b1, K_RET, 32'h0);
      chk("R5 nested", p_npc_o, 32'h1000 * i + 32'h4);
    end
    for (int k = 1; k <= 9; k++) fetch(32'h10 * k, 1'b1, K_CALL, 32'h8);
    for (int k = 9; k >= 2; k--) begin
      fetch(32'h60, 1'b1, K_RET, 32'h0);
      chk("R6 overflow order", p_npc_o, 32'h10 * k + 32'h4);
    end
    fetch(32'h60, 1'b1, K_RET, 32'h0);
    chk("R6 empty pop", p_npc_o, 32'h94);
    fetch(32'h60, 1'b1, K_RET, 32'h0);
    chk("R6 empty pop again", p_npc_o, 32'h94);
  endtask

  task automatic t_ibuf();
    fetch(32'h400, 1'b1, K_IND, 32'h0);
    chk("R7 miss npc", p_npc_o, 32'h404);
    chk("R7 miss nt", {31'b0, p_taken_o}, 32'h0);
    upd(32'h400, K_IND, 1'b1, 32'h8000, 32'h0, 8'h0, 1'b1);
    fetch(32'h400, 1'b1, K_IND, 32'h0);
    chk("R7 hit", p_npc_o, 32'h8000);
    chk("R7 hit taken", {31'b0, p_taken_o}, 32'h1);
    upd(32'h500, K_DIR, 1'b1, 32'h9000, 32'h0, 8'h0, 1'b0);
    fetch(32'h500, 1'b1, K_IND, 32'h0);
    chk("R7 direct not stored", p_npc_o, 32'h504);
    for (int i = 1; i <= 8; i++)
      upd(32'h400 + 32'h10 * i, K_IND, 1'b1, 32'h8000 + 32'h100 * i, 32'h0, 8'h0, 1'b0);
    fetch(32'h400, 1'b1, K_IND, 32'h0);
    chk("R8 oldest evicted", p_npc_o, 32'h404);
    fetch(32'h480, 1'b1, K_IND, 32'h0);
    chk("R8 newest", p_npc_o, 32'h8800);
    fetch(32'h410, 1'b1, K_IND, 32'h0);
    chk("R8 resident", p_npc_o, 32'h8100);
    upd(32'h420, K_IND, 1'b1, 32'hA000, 32'h0, 8'h0, 1'b1);
    upd(32'h430, K_IND, 1'b1, 32'h8300, 32'h0, 8'h0, 1'b0);
    fetch(32'h410, 1'b1, K_IND, 32'h0);
    chk("R8 no realloc", p_npc_o, 32'h8100);
    fetch(32'h420, 1'b1, K_IND, 32'h0);
    chk("R8 in place", p_npc_o, 32'hA000);
    fetch(32'h430, 1'b1, K_IND, 32'h0);
    chk("R8 same target kept", p_npc_o, 32'h8300);
  endtask

  task automatic t_tic();
    upd(32'h600, K_CALL, 1'b1, 32'h640, 32'hC0DE0000, 8'h0, 1'b0);
    fetch(32'h600, 1'b1, K_CALL, 32'h40);
    chk("R9 hit", {31'b0, p_tic_hit_o}, 32'h1);
    chk("R9 instr", p_tic_instr_o, 32'hC0DE0000);
    fetch(32'h600, 1'b0, K_DIR, 32'h0);
    chk("R9 non-branch no hit", {31'b0, p_tic_hit_o}, 32'h0);
    fetch(32'h610, 1'b1, K_CALL, 32'h40);
    chk("R9 miss", {31'b0, p_tic_hit_o}, 32'h0);
    for (int i = 1; i <= 4; i++)
      upd(32'h600 + 32'h10 * i, K_CALL, 1'b1, 32'h0, 32'hC0DE0000 + i, 8'h0, 1'b0);
    fetch(32'h600, 1'b1, K_CALL, 32'h40);
    chk("R9 evicted", {31'b0, p_tic_hit_o}, 32'h0);
    fetch(32'h640, 1'b1, K_CALL, 32'h40);
    chk("R9 newest instr", p_tic_instr_o, 32'hC0DE0004);
  endtask

  task automatic t_flush();
    @(negedge clk_i);
    idle_inputs();
    flush_i = 1'b1;
    fetch(32'h480, 1'b1, K_IND, 32'h0);
    chk("R10 ibuf cleared", p_npc_o, 32'h484);
    fetch(32'h640, 1'b1, K_CALL, 32'h40);
    chk("R10 tic cleared", {31'b0, p_tic_hit_o}, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_dir();
    t_ras();
    t_ibuf();
    t_tic();
    t_flush();
    @(negedge clk_i);
    idle_inputs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule